// File: doc/BRIEF.md
# In-Order Thread-Block Dispatcher

This block feeds thread blocks from a queue of kernel launches to a small array of streaming multiprocessors (SMs). Each launch states how many blocks the kernel has and what each block needs: thread slots and registers. Every block also takes one block slot. The dispatcher keeps its own ledger of each SM's free threads, registers and block slots. It places blocks one per clock on an SM that can hold them, and returns the resources when the SM reports that a block has finished. A placed block stays on its SM until it finishes.

Placement is strictly in launch order. Every block of one kernel is placed before any block of the next kernel. Up to sixteen kernels can be resident at once, where resident means accepted and not yet fully completed. The kernel ID is the table slot the kernel occupies. A launch whose per-block needs could never fit on any SM, or that has no blocks, is rejected with an error pulse. This keeps the dispatcher from waiting forever.

The control is a three-state machine:
- **Idle**: no kernel has unplaced blocks. It moves to Issue once the order queue holds a kernel.
- **Issue**: one block is dispatched in every cycle in which some SM fits. It returns to Idle when the queue is empty. It moves to Stall when no SM fits and no completion arrives in that cycle.
- **Stall**: nothing is dispatched. It moves back to Issue on the next completion pulse.

Top module: `blkd_dispatch`

## Requirements
- R1: A block is dispatched only to an SM whose free threads, free registers and free block slots each cover the block's needs. Every SM starts with full capacity. A dispatch subtracts the block's needs from its SM. A completion pulse adds back the amounts it carries plus one block slot.
- R2: The chosen SM is the first SM that fits, scanning upward and wrapping, starting one past the SM chosen by the previous dispatch. After reset the scan starts at SM 0.
- R3: Kernels are served in the order their launches were accepted. No block of a later kernel is dispatched while an earlier kernel still has unplaced blocks. No dispatch occurs when no kernel has unplaced blocks.
- R4: At most one dispatch occurs per cycle. Within a kernel, block IDs are dispatched exactly once each, as 0, 1, 2 and so on up to the block count minus one.
- R5: While a kernel has unplaced blocks and some SM fits the next one, the dispatcher idles for at most one cycle. Resources returned by a completion pulse can be used by a dispatch in the next cycle.
- R6: An accepted, valid launch receives the lowest-numbered free table slot (0 to 15) as its kernel ID.
- R7: `launch_ready` is low exactly when all sixteen kernel slots are resident. It is high otherwise.
- R8: An accepted launch with a block count of 0, per-block threads above the SM thread capacity, or per-block registers above the SM register capacity raises `launch_err` for one cycle, in the cycle after acceptance. Such a launch takes no slot and produces no dispatch.
- R9: In the cycle after the completion pulse of a kernel's last outstanding block is taken, `retire_valid` pulses with that kernel's ID, and the slot becomes free.
- R10: During reset and right after it: no dispatch, no error pulse, no retire pulse, and `launch_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch descriptor offered |
| launch_ready | output | 1 | A kernel slot is free; the launch is taken on valid and ready |
| launch_blocks | input | BLK_W | Number of blocks in the kernel |
| launch_threads | input | THR_W+1 | Thread slots needed per block |
| launch_regs | input | REG_W+1 | Registers needed per block |
| launch_err | output | 1 | Pulse: the last accepted launch was rejected |
| done_valid | input | 1 | A block has completed |
| done_sm | input | SMW | SM on which it ran |
| done_kid | input | KW | Kernel the block belongs to |
| done_threads | input | THR_W | Thread slots returned |
| done_regs | input | REG_W | Registers returned |
| disp_valid | output | 1 | Dispatch command this cycle |
| disp_kid | output | KW | Kernel ID of the dispatched block |
| disp_bid | output | BLK_W | Block ID within the kernel |
| disp_sm | output | SMW | Target SM |
| retire_valid | output | 1 | Pulse: a kernel has fully completed |
| retire_kid | output | KW | ID of the retiring kernel |

## Verification
If an SM's ledger entry is corrupted, the fault shows up as a wrong `disp_sm` on the very next dispatch that scans past that SM. An over-commit shows up as a block placed where the bench's own ledger has no room. A lost completion can show up much later, as a kernel that never retires or an SM that stays full. A wrong block counter or a wrong order-queue pointer shows up in the first dispatch after it goes wrong, as a repeated or skipped block ID or as a kernel served out of order. A Stall state that does not wake up shows up within two cycles as idling while the bench knows an SM fits.

// File: rtl/blkd_pkg.sv
package blkd_pkg;

    // Dispatch controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STALL = 2'd2
    } disp_state_e;

endpackage

// File: rtl/blkd_sm_ledger.sv
// Per-SM free resource ledger; reports which SMs can take the current block.
module blkd_sm_ledger #(
    parameter int NUM_SM     = 4,
    parameter int SM_THREADS = 1024,
    parameter int SM_REGS    = 16384,
    parameter int SM_SLOTS   = 8,
    localparam int SMW    = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
    localparam int THR_W  = $clog2(SM_THREADS + 1),
    localparam int REG_W  = $clog2(SM_REGS + 1),
    localparam int SLOT_W = $clog2(SM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  need_thr,
    input  logic [REG_W-1:0]  need_reg,
    input  logic              take_en,
    input  logic [SMW-1:0]    take_sm,
    input  logic              give_en,
    input  logic [SMW-1:0]    give_sm,
    input  logic [THR_W-1:0]  give_thr,
    input  logic [REG_W-1:0]  give_reg,
    output logic [NUM_SM-1:0] fit
);

    for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
        logic [THR_W-1:0]  free_thr;
        logic [REG_W-1:0]  free_reg;
        logic [SLOT_W-1:0] free_slot;
        logic              take_here;
        logic              give_here;

        assign take_here = take_en && (take_sm == SMW'(g));
        assign give_here = give_en && (give_sm == SMW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                free_thr  <= THR_W'(SM_THREADS);
                free_reg  <= REG_W'(SM_REGS);
                free_slot <= SLOT_W'(SM_SLOTS);
            end else begin
                free_thr  <= free_thr - (take_here ? need_thr : {THR_W{1'b0}})
                                      + (give_here ? give_thr : {THR_W{1'b0}});
                free_reg  <= free_reg - (take_here ? need_reg : {REG_W{1'b0}})
                                      + (give_here ? give_reg : {REG_W{1'b0}});
                free_slot <= free_slot - SLOT_W'(take_here) + SLOT_W'(give_here);
            end
        end

        assign fit[g] = (free_thr >= need_thr) && (free_reg >= need_reg)
                        && (free_slot != '0);

        // The ledger never holds more than the SM's capacity.
        p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (free_thr <= THR_W'(SM_THREADS)) && (free_reg <= REG_W'(SM_REGS))
            && (free_slot <= SLOT_W'(SM_SLOTS)));

        // The controller only takes from an SM that reports room.
        p_take_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
            take_here |-> fit[g]);
    end

endmodule

// File: rtl/blkd_rr_pick.sv
// Round-robin choice of the first fitting SM after the last one used.
module blkd_rr_pick #(
    parameter int NUM_SM = 4,
    localparam int SMW = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SM-1:0] fit,
    input  logic              adv,
    output logic              found,
    output logic [SMW-1:0]    pick
);

    logic [SMW-1:0] last_q;

    always_comb begin
        logic [SMW-1:0] cand;
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= NUM_SM; i++) begin
            cand = SMW'((int'(last_q) + i) % NUM_SM);
            if (!found && fit[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= SMW'(NUM_SM - 1);
        end else if (adv) begin
            last_q <= pick;
        end
    end

    // An advance is only requested when a choice exists.
    p_adv_found_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> found);

endmodule

// File: rtl/blkd_kernel_table.sv
// Resident kernel slots, launch screening, in-order queue and retirement.
module blkd_kernel_table #(
    parameter int MAX_KERN   = 16,
    parameter int BLK_W      = 8,
    parameter int SM_THREADS = 1024,
    parameter int SM_REGS    = 16384,
    localparam int KW     = (MAX_KERN > 1) ? $clog2(MAX_KERN) : 1,
    localparam int CNT_W  = $clog2(MAX_KERN + 1),
    localparam int THR_W  = $clog2(SM_THREADS + 1),
    localparam int REG_W  = $clog2(SM_REGS + 1),
    localparam int NEED_T = THR_W + 1,
    localparam int NEED_R = REG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_blocks,
    input  logic [NEED_T-1:0] in_thr,
    input  logic [NEED_R-1:0] in_reg,
    output logic              err_pulse,
    output logic              cur_valid,
    output logic [KW-1:0]     cur_kid,
    output logic [BLK_W-1:0]  cur_bid,
    output logic [THR_W-1:0]  cur_thr,
    output logic [REG_W-1:0]  cur_reg,
    input  logic              adv,
    input  logic              done_en,
    input  logic [KW-1:0]     done_kid,
    output logic              retire_en,
    output logic [KW-1:0]     retire_kid
);

    logic [MAX_KERN-1:0] busy;
    logic [BLK_W-1:0]    total    [MAX_KERN];
    logic [BLK_W-1:0]    placed   [MAX_KERN];
    logic [BLK_W-1:0]    finished [MAX_KERN];
    logic [THR_W-1:0]    thr_q    [MAX_KERN];
    logic [REG_W-1:0]    reg_q    [MAX_KERN];
    logic [KW-1:0]       order_q  [MAX_KERN];
    logic [KW-1:0]       rd_ptr, wr_ptr;
    logic [CNT_W-1:0]    qcnt;
    logic                err_q, ret_q;
    logic [KW-1:0]       ret_kid_q;

    logic          free_ok;
    logic [KW-1:0] free_idx;
    logic          bad, acc, alloc, last_blk, done_last;

    function automatic logic [KW-1:0] bump(input logic [KW-1:0] p);
        return (p == KW'(MAX_KERN - 1)) ? '0 : p + KW'(1);
    endfunction

    // Lowest free slot.
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int k = MAX_KERN - 1; k >= 0; k--) begin
            if (!busy[k]) begin
                free_ok  = 1'b1;
                free_idx = KW'(k);
            end
        end
    end

    assign in_ready  = free_ok;
    assign bad       = (in_blocks == '0) || (in_thr > NEED_T'(SM_THREADS))
                       || (in_reg > NEED_R'(SM_REGS));
    assign acc       = in_valid && in_ready;
    assign alloc     = acc && !bad;

    assign cur_valid = (qcnt != '0);
    assign cur_kid   = order_q[rd_ptr];
    assign cur_bid   = placed[cur_kid];
    assign cur_thr   = thr_q[cur_kid];
    assign cur_reg   = reg_q[cur_kid];
    assign last_blk  = adv && (placed[cur_kid] == total[cur_kid] - BLK_W'(1));
    assign done_last = done_en && (finished[done_kid] == total[done_kid] - BLK_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= '0;
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            qcnt      <= '0;
            err_q     <= 1'b0;
            ret_q     <= 1'b0;
            ret_kid_q <= '0;
            for (int k = 0; k < MAX_KERN; k++) begin
                total[k]    <= '0;
                placed[k]   <= '0;
                finished[k] <= '0;
                thr_q[k]    <= '0;
                reg_q[k]    <= '0;
                order_q[k]  <= '0;
            end
        end else begin
            err_q     <= acc && bad;
            ret_q     <= done_last;
            ret_kid_q <= done_kid;
            if (alloc) begin
                busy[free_idx]     <= 1'b1;
                total[free_idx]    <= in_blocks;
                placed[free_idx]   <= '0;
                finished[free_idx] <= '0;
                thr_q[free_idx]    <= in_thr[THR_W-1:0];
                reg_q[free_idx]    <= in_reg[REG_W-1:0];
                order_q[wr_ptr]    <= free_idx;
                wr_ptr             <= bump(wr_ptr);
            end
            if (adv) begin
                placed[cur_kid] <= placed[cur_kid] + BLK_W'(1);
            end
            if (last_blk) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (done_en) begin
                finished[done_kid] <= finished[done_kid] + BLK_W'(1);
            end
            if (done_last) begin
                busy[done_kid] <= 1'b0;
            end
            qcnt <= qcnt + CNT_W'(alloc) - CNT_W'(last_blk);
        end
    end

    assign err_pulse  = err_q;
    assign retire_en  = ret_q;
    assign retire_kid = ret_kid_q;

    // The order queue never holds more kernels than there are slots.
    p_queue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt <= CNT_W'(MAX_KERN));

    // A dispatch only consumes a block the current kernel still has.
    p_adv_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (cur_valid && (placed[cur_kid] < total[cur_kid])));

    // With every slot taken, no launch is accepted.
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !in_ready);

    // A rejected launch leaves the slot set as it was.
    p_err_keeps_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bad && !done_en) |=> (busy == $past(busy)));

    // Completions only refer to resident kernels.
    p_done_resident_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_en |-> busy[done_kid]);

    // A retiring kernel has released its slot.
    p_retire_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_q |-> !busy[ret_kid_q]);

endmodule

// File: rtl/blkd_dispatch.sv
// In-order thread-block dispatcher: top level with the issue controller.
module blkd_dispatch
    import blkd_pkg::*;
#(
    parameter int NUM_SM     = 4,
    parameter int MAX_KERN   = 16,
    parameter int BLK_W      = 8,
    parameter int SM_THREADS = 1024,
    parameter int SM_REGS    = 16384,
    parameter int SM_SLOTS   = 8,
    localparam int SMW   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
    localparam int KW    = (MAX_KERN > 1) ? $clog2(MAX_KERN) : 1,
    localparam int THR_W = $clog2(SM_THREADS + 1),
    localparam int REG_W = $clog2(SM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_valid,
    output logic             launch_ready,
    input  logic [BLK_W-1:0] launch_blocks,
    input  logic [THR_W:0]   launch_threads,
    input  logic [REG_W:0]   launch_regs,
    output logic             launch_err,
    input  logic             done_valid,
    input  logic [SMW-1:0]   done_sm,
    input  logic [KW-1:0]    done_kid,
    input  logic [THR_W-1:0] done_threads,
    input  logic [REG_W-1:0] done_regs,
    output logic             disp_valid,
    output logic [KW-1:0]    disp_kid,
    output logic [BLK_W-1:0] disp_bid,
    output logic [SMW-1:0]   disp_sm,
    output logic             retire_valid,
    output logic [KW-1:0]    retire_kid
);

    disp_state_e state_q, state_d;

    logic              cur_valid;
    logic [KW-1:0]     cur_kid;
    logic [BLK_W-1:0]  cur_bid;
    logic [THR_W-1:0]  cur_thr;
    logic [REG_W-1:0]  cur_reg;
    logic [NUM_SM-1:0] fit;
    logic              found;
    logic [SMW-1:0]    pick;

    blkd_kernel_table #(
        .MAX_KERN   (MAX_KERN),
        .BLK_W      (BLK_W),
        .SM_THREADS (SM_THREADS),
        .SM_REGS    (SM_REGS)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (launch_valid),
        .in_ready   (launch_ready),
        .in_blocks  (launch_blocks),
        .in_thr     (launch_threads),
        .in_reg     (launch_regs),
        .err_pulse  (launch_err),
        .cur_valid  (cur_valid),
        .cur_kid    (cur_kid),
        .cur_bid    (cur_bid),
        .cur_thr    (cur_thr),
        .cur_reg    (cur_reg),
        .adv        (disp_valid),
        .done_en    (done_valid),
        .done_kid   (done_kid),
        .retire_en  (retire_valid),
        .retire_kid (retire_kid)
    );

    blkd_sm_ledger #(
        .NUM_SM     (NUM_SM),
        .SM_THREADS (SM_THREADS),
        .SM_REGS    (SM_REGS),
        .SM_SLOTS   (SM_SLOTS)
    ) u_ledger (
        .clk      (clk),
        .rst_n    (rst_n),
        .need_thr (cur_thr),
        .need_reg (cur_reg),
        .take_en  (disp_valid),
        .take_sm  (pick),
        .give_en  (done_valid),
        .give_sm  (done_sm),
        .give_thr (done_threads),
        .give_reg (done_regs),
        .fit      (fit)
    );

    blkd_rr_pick #(
        .NUM_SM (NUM_SM)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .fit   (fit),
        .adv   (disp_valid),
        .found (found),
        .pick  (pick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cur_valid) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (!cur_valid) begin
                    state_d = ST_IDLE;
                end else if (!found && !done_valid) begin
                    state_d = ST_STALL;
                end
            end
            ST_STALL: begin
                if (done_valid) state_d = ST_ISSUE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        disp_valid = 1'b0;
        unique case (state_q)
            ST_ISSUE: disp_valid = cur_valid && found;
            ST_IDLE,
            ST_STALL: disp_valid = 1'b0;
            default:  disp_valid = 1'b0;
        endcase
        disp_kid = cur_kid;
        disp_bid = cur_bid;
        disp_sm  = pick;
    end

    // Stall is only held for a kernel that still has unplaced blocks.
    p_stall_has_work_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> cur_valid);

    // A completion while stalled reopens issue at once.
    p_stall_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STALL) && done_valid) |=> (state_q == ST_ISSUE));

    // No dispatch with an empty order queue.
    p_no_phantom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> cur_valid);

endmodule

// File: tb/test_blkd_dispatch.sv
module test_blkd_dispatch;

    localparam int NUM_SM = 4, MAX_KERN = 16, BLK_W = 8;
    localparam int SM_THREADS = 1024, SM_REGS = 16384, SM_SLOTS = 8;
    localparam int SMW = 2, KW = 4, THR_W = 11, REG_W = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_valid = 1'b0, launch_ready;
    logic [BLK_W-1:0] launch_blocks = '0;
    logic [THR_W:0]   launch_threads = '0;
    logic [REG_W:0]   launch_regs = '0;
    logic launch_err;
    logic done_valid = 1'b0;
    logic [SMW-1:0]   done_sm = '0;
    logic [KW-1:0]    done_kid = '0;
    logic [THR_W-1:0] done_threads = '0;
    logic [REG_W-1:0] done_regs = '0;
    logic disp_valid;
    logic [KW-1:0]    disp_kid;
    logic [BLK_W-1:0] disp_bid;
    logic [SMW-1:0]   disp_sm;
    logic retire_valid;
    logic [KW-1:0]    retire_kid;

    always #4 clk = ~clk;

    blkd_dispatch #(
        .NUM_SM(NUM_SM), .MAX_KERN(MAX_KERN), .BLK_W(BLK_W),
        .SM_THREADS(SM_THREADS), .SM_REGS(SM_REGS), .SM_SLOTS(SM_SLOTS)
    ) i_blkd_dispatch (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_ready(launch_ready),
        .launch_blocks(launch_blocks), .launch_threads(launch_threads),
        .launch_regs(launch_regs), .launch_err(launch_err),
        .done_valid(done_valid), .done_sm(done_sm), .done_kid(done_kid),
        .done_threads(done_threads), .done_regs(done_regs),
        .disp_valid(disp_valid), .disp_kid(disp_kid), .disp_bid(disp_bid),
        .disp_sm(disp_sm), .retire_valid(retire_valid), .retire_kid(retire_kid)
    );

    int checks = 0, errors = 0;
    bit finished_run = 0;

    // Reference model
    int free_t[NUM_SM], free_r[NUM_SM], free_s[NUM_SM];
    int last_sm;
    bit kbusy[MAX_KERN];
    int ktot[MAX_KERN], kthr[MAX_KERN], kreg[MAX_KERN], kplaced[MAX_KERN], kfin[MAX_KERN];
    int oq[$];
    int rsm[64], rkid[64], rn;
    int lq_b[$], lq_t[$], lq_r[$];
    bit allow_done;
    bit exp_err, exp_ret;
    int ret_kid_exp;
    int idle;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit fits(int s, int t, int r);
        return free_t[s] >= t && free_r[s] >= r && free_s[s] > 0;
    endfunction

    function automatic int exp_pick(int t, int r);
        for (int i = 1; i <= NUM_SM; i++) begin
            int c = (last_sm + i) % NUM_SM;
            if (fits(c, t, r)) return c;
        end
        return -1;
    endfunction

    function automatic int lowest_free();
        for (int k = 0; k < MAX_KERN; k++) if (!kbusy[k]) return k;
        return -1;
    endfunction

    function automatic int resident_count();
        int n = 0;
        for (int k = 0; k < MAX_KERN; k++) if (kbusy[k]) n++;
        return n;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NUM_SM; s++) begin
            free_t[s] = SM_THREADS; free_r[s] = SM_REGS; free_s[s] = SM_SLOTS;
        end
        for (int k = 0; k < MAX_KERN; k++) begin
            kbusy[k] = 0; kplaced[k] = 0; kfin[k] = 0; ktot[k] = 0;
        end
        last_sm = NUM_SM - 1;
        oq.delete();
        rn = 0; exp_err = 0; exp_ret = 0; idle = 0; allow_done = 1;
    endtask

    task automatic push_launch(int b, int t, int r);
        lq_b.push_back(b); lq_t.push_back(t); lq_r.push_back(r);
    endtask

    // One clock: observe at the falling edge, update the model, drive inputs.
    task automatic step();
        int k, e, s, idx, kid;
        @(negedge clk);
        check(launch_err == exp_err, "R8", "error pulse", launch_err, exp_err);
        check(retire_valid == exp_ret, "R9", "retire pulse", retire_valid, exp_ret);
        if (exp_ret && retire_valid)
            check(retire_kid == ret_kid_exp, "R9", "retire kernel id", retire_kid, ret_kid_exp);
        check(launch_ready == (resident_count() < MAX_KERN), "R7", "launch ready",
              launch_ready, resident_count() < MAX_KERN);
        if (oq.size() > 0) begin
            k = oq[0];
            e = exp_pick(kthr[k], kreg[k]);
            if (disp_valid) begin
                s = int'(disp_sm);
                check(fits(s, kthr[k], kreg[k]), "R1", "target SM has room", s, e);
                check(disp_kid == k, "R3 R6", "kernel id in order", disp_kid, k);
                check(disp_bid == kplaced[k], "R4", "block id", disp_bid, kplaced[k]);
                check(s == e, "R2", "round-robin SM", s, e);
                idle = 0;
                free_t[s] -= kthr[k]; free_r[s] -= kreg[k]; free_s[s] -= 1;
                rsm[rn] = s; rkid[rn] = k; rn++;
                last_sm = s;
                kplaced[k]++;
                if (kplaced[k] == ktot[k]) void'(oq.pop_front());
            end else if (e >= 0) begin
                idle++;
                if (idle >= 2) check(0, "R5", "idle cycles while an SM fits", idle, 1);
            end else begin
                idle = 0;
            end
        end else begin
            idle = 0;
            if (disp_valid) check(0, "R3", "dispatch with no pending kernel", 1, 0);
        end

        exp_err = 0; exp_ret = 0;
        launch_valid = 0; done_valid = 0;
        if (lq_b.size() > 0) begin
            launch_valid   = 1;
            launch_blocks  = BLK_W'(lq_b[0]);
            launch_threads = (THR_W+1)'(lq_t[0]);
            launch_regs    = (REG_W+1)'(lq_r[0]);
            if (launch_ready) begin
                if (lq_b[0] == 0 || lq_t[0] > SM_THREADS || lq_r[0] > SM_REGS) begin
                    exp_err = 1;
                end else begin
                    kid = lowest_free();
                    kbusy[kid] = 1; ktot[kid] = lq_b[0]; kthr[kid] = lq_t[0];
                    kreg[kid] = lq_r[0]; kplaced[kid] = 0; kfin[kid] = 0;
                    oq.push_back(kid);
                end
                void'(lq_b.pop_front()); void'(lq_t.pop_front()); void'(lq_r.pop_front());
            end
        end
        if (allow_done && rn > 0 && $urandom_range(0, 2) == 0) begin
            idx = $urandom_range(0, rn - 1);
            k = rkid[idx]; s = rsm[idx];
            done_valid = 1; done_sm = SMW'(s); done_kid = KW'(k);
            done_threads = THR_W'(kthr[k]); done_regs = REG_W'(kreg[k]);
            free_t[s] += kthr[k]; free_r[s] += kreg[k]; free_s[s] += 1;
            rsm[idx] = rsm[rn-1]; rkid[idx] = rkid[rn-1]; rn--;
            kfin[k]++;
            if (kfin[k] == ktot[k]) begin
                kbusy[k] = 0; exp_ret = 1; ret_kid_exp = k;
            end
        end
    endtask

    task automatic drain(int cap);
        int n = 0;
        while ((lq_b.size() > 0 || rn > 0 || oq.size() > 0 || resident_count() > 0) && n < cap) begin
            step(); n++;
        end
        repeat (3) step();
        check(resident_count() == 0 && rn == 0, "R9", "all kernels retired",
              resident_count(), 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished_run) begin
            errors++; checks++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(disp_valid == 0, "R10", "no dispatch in reset", disp_valid, 0);
        check(launch_ready == 1, "R10", "ready in reset", launch_ready, 1);
        check(retire_valid == 0, "R10", "no retire in reset", retire_valid, 0);
        check(launch_err == 0, "R10", "no error in reset", launch_err, 0);
        rst_n = 1;
        repeat (2) step();
        check(disp_valid == 0 && launch_ready == 1, "R10", "idle after reset",
              disp_valid, 0);

        // R8: rejected launches, then a valid one
        push_launch(0, 64, 64);
        push_launch(3, SM_THREADS + 1, 64);
        push_launch(2, 64, SM_REGS + 1);
        push_launch(5, 256, 1024);
        drain(2000);

        // R7: fill all sixteen slots while completions are held back
        allow_done = 0;
        for (int i = 0; i < 17; i++) push_launch(1, 32, 64);
        repeat (40) step();
        check(resident_count() == 16, "R7", "resident kernels", resident_count(), 16);
        check(launch_ready == 0, "R7", "ready low when full", launch_ready, 0);
        check(lq_b.size() == 1, "R7", "seventeenth launch held", lq_b.size(), 1);
        allow_done = 1;
        drain(3000);

        // R5: blocks that each fill an SM, followed by a small kernel in order
        push_launch(9, SM_THREADS, 100);
        push_launch(3, 64, 256);
        drain(3000);

        // Random mix with occasional rejected launches
        for (int i = 0; i < 40; i++) begin
            int b = $urandom_range(1, 12);
            int t = 32 * $urandom_range(1, 16);
            int r = 128 * $urandom_range(1, 64);
            if ($urandom_range(0, 9) == 0) t = SM_THREADS + 32;
            push_launch(b, t, r);
        end
        drain(60000);

        finished_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule